// File: doc/BRIEF.md
# Per-channel DAC code trim unit

This unit sits between the code source and the converter registers of a multi-channel 14-bit DAC. Every code bound for a channel passes through a straight-line correction. A gain term scales the code and an offset term shifts it, so that gain and offset errors in the analog chain can be cancelled digitally. Each channel keeps its own pair of trim words. These are loaded through a plain parallel write port, typically once at start-up from stored calibration data, or again later when the outputs are re-measured.

A code presented with its valid strobe and channel number comes out one cycle later, corrected and limited to the legal code range. It is accompanied by a load strobe and the same channel number, ready to be latched by the converter register. The correction is `out = floor((gain + 2) * in / 16384) + offset - 8192`. The reset trim words make this an exact identity.

Top module: `dac_trim_corr`

## Requirements
- R1: After reset every channel's gain word is 16382 and its offset word is 8192.
- R2: With the reset trim words, every channel returns the input code unchanged, for every input from 0 to 16383.
- R3: With gain word G and offset word C, the output is floor((G + 2) * X / 16384) + C - 8192 before limiting, where X is the input code.
- R4: A corrected value above 16383 is output as 16383.
- R5: A corrected value below 0 is output as 0.
- R6: A trim write to one channel changes no other channel's output.
- R7: loadStb is high in exactly the cycle after a cycle with codeValid high, with loadCh equal to the channel given with that code. In every other cycle loadStb is low and loadCode keeps its last value.
- R8: A trim write in the same cycle as a conversion on the same channel does not affect that conversion. It does affect the next conversion on that channel.
- R9: A write with wrSel = 0 loads the gain word and a write with wrSel = 1 loads the offset word, each for channel wrCh, from wrData.
- R10: While reset is held and just after it, loadStb, loadCh and loadCode are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Trim word write enable |
| wrSel | input | 1 | 0 selects the gain word, 1 selects the offset word |
| wrCh | input | 4 | Channel addressed by the write |
| wrData | input | 14 | Trim word value, unsigned |
| codeValid | input | 1 | Input code strobe |
| codeCh | input | 4 | Channel of the input code |
| codeIn | input | 14 | Uncorrected code |
| loadStb | output | 1 | Corrected code ready for the converter register |
| loadCh | output | 4 | Channel of the corrected code |
| loadCode | output | 14 | Corrected, limited code |

## Verification
A trim write and a code conversion can fall in the same cycle, and the interesting case is when both address the same channel and the same word. The bench issues such pairs on purpose, for both the gain and the offset word. It then converts again on that channel in the next cycle. Its model computes the expected code from the trim words as they stood before the write for the first conversion and after it for the second, so a design that forwards the new value early, or fails to keep it, is caught.

// File: rtl/dac_trim_pkg.sv
package dac_trim_pkg;
  typedef struct packed {
    logic wrGain;   // update one channel's gain word
    logic wrOff;    // update one channel's offset word
    logic capture;  // register a corrected code this cycle
  } trim_strb_t;
endpackage

// File: rtl/dac_trim_ctrl.sv
module dac_trim_ctrl
  import dac_trim_pkg::*;
#(
  parameter int NUM_CH = 16,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic            wrSel,
  input  logic            codeValid,
  input  logic [CH_W-1:0] codeCh,
  output trim_strb_t      strb,
  output logic            loadStb,
  output logic [CH_W-1:0] loadCh
);
  always_comb begin
    strb.wrGain  = wrEn && !wrSel;
    strb.wrOff   = wrEn && wrSel;
    strb.capture = codeValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadStb <= 1'b0;
      loadCh  <= '0;
    end else begin
      loadStb <= codeValid;
      if (codeValid) loadCh <= codeCh;
    end
  end
endmodule

// File: rtl/dac_trim_dp.sv
module dac_trim_dp
  import dac_trim_pkg::*;
#(
  parameter int CODE_W = 14,
  parameter int NUM_CH = 16,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int PROD_W = 2 * CODE_W,
  localparam int SUM_W  = CODE_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  trim_strb_t        strb,
  input  logic [CH_W-1:0]   wrCh,
  input  logic [CODE_W-1:0] wrData,
  input  logic [CH_W-1:0]   codeCh,
  input  logic [CODE_W-1:0] codeIn,
  output logic [CODE_W-1:0] loadCode
);
  localparam logic [CODE_W-1:0] GAIN_RST = CODE_W'((1 << CODE_W) - 2);
  localparam logic [CODE_W-1:0] OFF_RST  = CODE_W'(1 << (CODE_W - 1));
  localparam logic signed [SUM_W-1:0] MID  = SUM_W'(1 << (CODE_W - 1));
  localparam logic signed [SUM_W-1:0] CMAX = SUM_W'((1 << CODE_W) - 1);

  logic [CODE_W-1:0] gainWord [NUM_CH];
  logic [CODE_W-1:0] offWord  [NUM_CH];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rstN) begin
        gainWord[ch] <= GAIN_RST;
        offWord[ch]  <= OFF_RST;
      end else if (wrCh == CH_W'(ch)) begin
        if (strb.wrGain) gainWord[ch] <= wrData;
        if (strb.wrOff)  offWord[ch]  <= wrData;
      end
    end
  end

  logic [CODE_W-1:0]       selGain, selOff, scaled;
  logic [CODE_W:0]         gainTerm;
  logic [PROD_W-1:0]       prod;
  logic signed [SUM_W-1:0] sum;
  logic [CODE_W-1:0]       clamped;

  always_comb begin
    selGain  = gainWord[codeCh];
    selOff   = offWord[codeCh];
    gainTerm = {1'b0, selGain} + (CODE_W+1)'(2);
    prod     = PROD_W'(gainTerm) * PROD_W'(codeIn);
    scaled   = prod[PROD_W-1:CODE_W];
    sum      = $signed({2'b00, scaled}) + $signed({2'b00, selOff}) - MID;
    if (sum < 0)         clamped = '0;
    else if (sum > CMAX) clamped = CMAX[CODE_W-1:0];
    else                 clamped = sum[CODE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)             loadCode <= '0;
    else if (strb.capture) loadCode <= clamped;
  end
endmodule

// File: rtl/dac_trim_corr.sv
module dac_trim_corr
  import dac_trim_pkg::*;
#(
  parameter int CODE_W = 14,
  parameter int NUM_CH = 16,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [CH_W-1:0]   wrCh,
  input  logic [CODE_W-1:0] wrData,
  input  logic              codeValid,
  input  logic [CH_W-1:0]   codeCh,
  input  logic [CODE_W-1:0] codeIn,
  output logic              loadStb,
  output logic [CH_W-1:0]   loadCh,
  output logic [CODE_W-1:0] loadCode
);
  trim_strb_t strb;

  dac_trim_ctrl #(.NUM_CH(NUM_CH)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
    .codeValid(codeValid), .codeCh(codeCh),
    .strb(strb), .loadStb(loadStb), .loadCh(loadCh)
  );

  dac_trim_dp #(.CODE_W(CODE_W), .NUM_CH(NUM_CH)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrCh(wrCh), .wrData(wrData),
    .codeCh(codeCh), .codeIn(codeIn), .loadCode(loadCode)
  );
endmodule

// File: rtl/dac_trim_chk.sv
module dac_trim_chk #(
  parameter int CODE_W = 14,
  parameter int NUM_CH = 16,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              wrSel,
  input logic [CH_W-1:0]   wrCh,
  input logic [CODE_W-1:0] wrData,
  input logic              codeValid,
  input logic [CH_W-1:0]   codeCh,
  input logic [CODE_W-1:0] codeIn,
  input logic              loadStb,
  input logic [CH_W-1:0]   loadCh,
  input logic [CODE_W-1:0] loadCode
);
  int shGain [NUM_CH];
  int shOff  [NUM_CH];
  int expCode;

  function automatic int refCode(int g, int c, int x);
    int v;
    v = (((g + 2) * x) >>> CODE_W) + c - (1 << (CODE_W - 1));
    if (v < 0) v = 0;
    if (v > (1 << CODE_W) - 1) v = (1 << CODE_W) - 1;
    return v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CH; i++) begin
        shGain[i] <= (1 << CODE_W) - 2;
        shOff[i]  <= 1 << (CODE_W - 1);
      end
      expCode <= 0;
    end else begin
      if (codeValid) expCode <= refCode(shGain[codeCh], shOff[codeCh], int'(codeIn));
      if (wrEn && !wrSel) shGain[wrCh] <= int'(wrData);
      if (wrEn && wrSel)  shOff[wrCh]  <= int'(wrData);
    end
  end

  // R7
  strobe_follows_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    codeValid |=> loadStb);
  // R7
  no_stray_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !codeValid |=> !loadStb);
  // R7
  channel_tag_chk: assert property (@(posedge clk) disable iff (!rstN)
    codeValid |=> (loadCh == $past(codeCh)));
  // R7
  code_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !codeValid |=> $stable(loadCode));
  // R3
  corrected_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |-> (int'(loadCode) == expCode));
endmodule

bind dac_trim_corr dac_trim_chk #(.CODE_W(CODE_W), .NUM_CH(NUM_CH)) i_chk (.*);

// File: tb/test_dac_trim_corr.sv
module test_dac_trim_corr;
  localparam int CODE_W = 14;
  localparam int NUM_CH = 16;
  localparam int CH_W = $clog2(NUM_CH);

  logic clk = 1'b0;
  logic rstN;
  logic wrEn, wrSel, codeValid;
  logic [CH_W-1:0] wrCh, codeCh, loadCh;
  logic [CODE_W-1:0] wrData, codeIn, loadCode;
  logic loadStb;

  int checks = 0;
  int failures = 0;
  int mGain [NUM_CH];
  int mOff  [NUM_CH];
  int lastCode = 0;

  always #5ns clk = ~clk;

  dac_trim_corr i_dac_trim_corr (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrCh(wrCh),
    .wrData(wrData), .codeValid(codeValid), .codeCh(codeCh), .codeIn(codeIn),
    .loadStb(loadStb), .loadCh(loadCh), .loadCode(loadCode)
  );

  function automatic int model(int ch, int x);
    int v;
    v = (((mGain[ch] + 2) * x) / 16384) + mOff[ch] - 8192;
    if (v < 0) v = 0;
    if (v > 16383) v = 16383;
    return v;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(bit we, bit sel, int wch, int wd, bit v, int cch, int cx, string tag);
    int exp;
    @(negedge clk);
    wrEn = we; wrSel = sel; wrCh = CH_W'(wch); wrData = CODE_W'(wd);
    codeValid = v; codeCh = CH_W'(cch); codeIn = CODE_W'(cx);
    @(posedge clk);
    exp = v ? model(cch, cx) : lastCode;
    lastCode = exp;
    if (we && !sel) mGain[wch] = wd;
    if (we && sel)  mOff[wch]  = wd;
    #1ns;
    chk(loadStb == v, {tag, " R7 strobe"}, int'(loadStb), int'(v));
    if (v) chk(int'(loadCh) == cch, {tag, " R7 channel"}, int'(loadCh), cch);
    chk(int'(loadCode) == exp, tag, int'(loadCode), exp);
  endtask

  task automatic conv(int ch, int x, string tag);
    step(0, 0, 0, 0, 1, ch, x, tag);
  endtask

  task automatic wr(bit sel, int ch, int d);
    step(1, sel, ch, d, 0, 0, 0, "R9 write/R7 hold");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < NUM_CH; i++) begin mGain[i] = 16382; mOff[i] = 8192; end
    rstN = 1'b0; wrEn = 0; wrSel = 0; wrCh = '0; wrData = '0;
    codeValid = 0; codeCh = '0; codeIn = '0;
    repeat (3) @(posedge clk);
    #1ns;
    // R10
    chk(loadStb == 1'b0, "R10 strobe in reset", int'(loadStb), 0);
    chk(loadCode == '0, "R10 code in reset", int'(loadCode), 0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1ns;
    chk(loadStb == 1'b0 && loadCh == '0, "R10 after reset", int'(loadStb), 0);

    // R1 R2: identity on defaults, corners and a sweep
    conv(0, 0, "R1 R2 zero");
    conv(15, 16383, "R1 R2 full scale");
    conv(7, 8192, "R2 mid");
    for (int x = 1; x < 16384; x += 997) conv(x % NUM_CH, x, "R2 sweep");
    step(0, 0, 0, 0, 0, 0, 0, "R7 idle hold");

    // R9 R3: gain then offset on channel 3
    wr(0, 3, 16362);
    conv(3, 16383, "R3 R9 gain trimmed");
    wr(1, 3, 8176);
    conv(3, 16383, "R3 R9 gain+offset");
    conv(3, 0, "R3 offset at zero code");
    conv(3, 5000, "R3 mid code");
    // R6
    conv(0, 16383, "R6 neighbour untouched");
    conv(4, 5000, "R6 neighbour untouched");

    // R4
    wr(1, 5, 16383);
    conv(5, 16383, "R4 high clamp");
    conv(5, 8200, "R4 high clamp near edge");
    // R5
    wr(1, 6, 0);
    conv(6, 100, "R5 low clamp");
    conv(6, 8192, "R5 exact zero");
    wr(0, 7, 0);
    conv(7, 16383, "R3 minimum gain");

    // R8: write and conversion together on the same channel
    step(1, 0, 9, 8000, 1, 9, 12000, "R8 gain old value");
    conv(9, 12000, "R8 gain new value");
    step(1, 1, 9, 9000, 1, 9, 12000, "R8 offset old value");
    conv(9, 12000, "R8 offset new value");
    step(1, 1, 10, 100, 1, 11, 4000, "R6 R8 other channel");
    conv(10, 4000, "R8 written channel");
    step(0, 0, 0, 0, 0, 0, 0, "R7 idle hold");
    step(0, 0, 0, 0, 0, 0, 0, "R7 idle hold");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule